// File: doc/BRIEF.md
# Gated Retriggerable Channel Pulse Former

This block turns a bank of synchronised per-channel hit flags into timed output pulses, one former per channel. Each former watches for the rising edge of its hit flag and then holds its output high for a number of clock cycles. That cycle count comes from an 8-bit width code passed through a monotonic but non-linear curve. The lower half of the channels share one width code and the upper half share a second. A per-channel mode bit picks between two behaviours. In the first, a new hit restarts the timer. In the second, hits that arrive while the output is active are ignored, and the channel takes one recovery cycle before it can arm again.

Three common controls act on the bank. An enable mask switches channels on and off. A veto suppresses real hits on every channel. A common test trigger fires every enabled channel at once; it can come from the rising edge of an external test level or from a one-cycle strobe, and the veto does not block it. A single output reports the OR of all channel pulses.

Each former is a three-state machine. IDLE waits for a trigger. ACTIVE drives the output high and counts down. HOLDOFF is the recovery cycle used in non-retriggering mode. The transitions are:
- *arm*: IDLE to ACTIVE on a trigger.
- *reload*: ACTIVE to ACTIVE, with the counter reloaded, on a trigger in retriggering mode.
- *expire-retrig*: ACTIVE to IDLE when the count runs out in retriggering mode.
- *expire-hold*: ACTIVE to HOLDOFF when the count runs out in non-retriggering mode.
- *release*: HOLDOFF to IDLE after one cycle.
- *drop*: any state to IDLE whenever the channel's mask bit is 0.

Top module: `pulse_former_bank`

## Requirements
- R1: Width code c gives W = MIN_CYC + ((MAX_CYC-MIN_CYC)*c*c)/(255*255) cycles, using integer division, so code 0 gives MIN_CYC and code 255 gives MAX_CYC. A hit rising edge sampled at clock edge k drives the output high after edge k for exactly W cycles.
- R2: Channels below NUM_CH/2 take their width from the low-group code input. The remaining channels take their width from the high-group code input.
- R3: With mode bit 0 (non-retriggering), a rising edge sampled 1 to W+1 cycles after the accepted one is ignored. An edge sampled W+2 or more cycles later starts a new full pulse.
- R4: With mode bit 1 (retriggering), a rising edge sampled while the output is high keeps the output high until W cycles after that latest edge.
- R5: A hit held high for many cycles produces exactly one trigger.
- R6: A channel whose mask bit is 0 never drives its output. Clearing the bit during a pulse forces the output low in the same cycle and abandons the pulse.
- R7: A hit rising edge sampled while veto is high produces no pulse.
- R8: A test trigger fires every enabled channel in the same cycle, whether or not veto is high. The trigger is either a rising edge of the external test level or a strobe high for one cycle. Each channel's pulse uses its own group width.
- R9: The OR output is high in exactly the cycles in which at least one channel output is high.
- R10: During reset, and in the cycle that follows it, all channel outputs and the OR output are low. Reset abandons any running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | NUM_CH | Synchronised over-threshold flags, one per channel |
| mode_upd_i | input | NUM_CH | Per-channel mode: 1 retriggering, 0 non-retriggering |
| en_mask_i | input | NUM_CH | Per-channel enable: 1 enabled |
| veto_i | input | 1 | Common veto of real hits |
| test_i | input | 1 | External test level; its rising edge is a test trigger |
| test_strobe_i | input | 1 | One-cycle test trigger strobe |
| width_lo_i | input | CODE_W | Width code for the lower channel group |
| width_hi_i | input | CODE_W | Width code for the upper channel group |
| pulse_o | output | NUM_CH | Channel output pulses |
| or_o | output | 1 | OR of all channel outputs |

## Verification
The bench builds the block with its defaults: 16 channels, an 8-bit code, MIN_CYC of 2 and MAX_CYC of 20. With these values the widest pulse lasts only twenty cycles. Second hits can therefore be placed on every boundary in a short window: inside the pulse, exactly at W, W+1 and W+2, and beyond. Both channel groups can be given clearly different widths, so a group mix-up shows up at once.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        PF_IDLE    = 2'd0,
        PF_ACTIVE  = 2'd1,
        PF_HOLDOFF = 2'd2
    } pf_state_e;

    // Quadratic curve from code to cycle count: monotonic, non-linear,
    // endpoints pinned to lo and hi.
    function automatic int unsigned pf_width_cycles(
        input int unsigned code,
        input int unsigned code_max,
        input int unsigned lo,
        input int unsigned hi
    );
        int unsigned span;
        span = hi - lo;
        return lo + (span * code * code) / (code_max * code_max);
    endfunction

endpackage

// File: rtl/pf_width_map.sv
module pf_width_map
    import pf_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int MIN_CYC = 2,
    parameter int MAX_CYC = 20,
    parameter int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  cycles_o
);
    localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

    always_comb begin
        cycles_o = CNT_W'(pf_width_cycles(int'(code_i), CODE_MAX,
                                          MIN_CYC, MAX_CYC));
    end

endmodule

// File: rtl/pf_test_trig.sv
module pf_test_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic test_i,
    input  logic test_strobe_i,
    output logic test_fire_o
);
    logic test_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) test_q <= 1'b0;
        else        test_q <= test_i;
    end

    always_comb begin
        test_fire_o = (test_i & ~test_q) | test_strobe_i;
    end

endmodule

// File: rtl/pf_channel.sv
module pf_channel
    import pf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             en_i,
    input  logic             upd_i,
    input  logic             veto_i,
    input  logic             test_fire_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o
);
    pf_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit_q;
    logic             hit_rise;
    logic             trig;
    logic [CNT_W-1:0] reload;

    always_comb begin
        hit_rise = hit_i & ~hit_q;
        trig     = en_i & ((hit_rise & ~veto_i) | test_fire_i);
        reload   = width_i - CNT_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PF_IDLE;
            cnt_q   <= '0;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hit_q   <= hit_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en_i) begin
            state_d = PF_IDLE;            // drop
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PF_IDLE: begin
                    if (trig) begin       // arm
                        state_d = PF_ACTIVE;
                        cnt_d   = reload;
                    end
                end
                PF_ACTIVE: begin
                    if (upd_i && trig) begin
                        cnt_d = reload;   // reload
                    end else if (cnt_q == '0) begin
                        state_d = upd_i ? PF_IDLE : PF_HOLDOFF;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                PF_HOLDOFF: begin
                    state_d = PF_IDLE;    // release
                end
                default: begin
                    state_d = PF_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pulse_o = en_i && (state_q == PF_ACTIVE);
    end

    // R1
    arm_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == PF_IDLE && trig) |=> (state_q == PF_ACTIVE));

    // R3
    ignore_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !upd_i && state_q == PF_ACTIVE && cnt_q != '0)
        |=> (!en_i || (state_q == PF_ACTIVE && cnt_q == $past(cnt_q) - 1'b1)));

    // R3
    holdoff_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PF_HOLDOFF) |=> (state_q == PF_IDLE));

    // R4
    reload_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && upd_i && state_q == PF_ACTIVE && trig)
        |=> (!en_i || (state_q == PF_ACTIVE && cnt_q == $past(width_i) - 1'b1)));

    // R7
    veto_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PF_IDLE && veto_i && !test_fire_i) |=> (state_q == PF_IDLE));

endmodule

// File: rtl/pulse_former_bank.sv
module pulse_former_bank
    import pf_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int CODE_W  = 8,
    parameter int MIN_CYC = 2,
    parameter int MAX_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] mode_upd_i,
    input  logic [NUM_CH-1:0] en_mask_i,
    input  logic              veto_i,
    input  logic              test_i,
    input  logic              test_strobe_i,
    input  logic [CODE_W-1:0] width_lo_i,
    input  logic [CODE_W-1:0] width_hi_i,
    output logic [NUM_CH-1:0] pulse_o,
    output logic              or_o
);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam int GROUP = NUM_CH / 2;

    logic [CNT_W-1:0] cyc_lo, cyc_hi;
    logic             test_fire;

    pf_width_map #(.CODE_W(CODE_W), .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC),
                   .CNT_W(CNT_W)) u_map_lo (
        .code_i   (width_lo_i),
        .cycles_o (cyc_lo)
    );

    pf_width_map #(.CODE_W(CODE_W), .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC),
                   .CNT_W(CNT_W)) u_map_hi (
        .code_i   (width_hi_i),
        .cycles_o (cyc_hi)
    );

    pf_test_trig u_test (
        .clk           (clk),
        .rst_n         (rst_n),
        .test_i        (test_i),
        .test_strobe_i (test_strobe_i),
        .test_fire_o   (test_fire)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CNT_W-1:0] width_c;
        if (c < GROUP) begin : g_lo
            assign width_c = cyc_lo;
        end else begin : g_hi
            assign width_c = cyc_hi;
        end

        pf_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit_i       (hit_i[c]),
            .en_i        (en_mask_i[c]),
            .upd_i       (mode_upd_i[c]),
            .veto_i      (veto_i),
            .test_fire_i (test_fire),
            .width_i     (width_c),
            .pulse_o     (pulse_o[c])
        );
    end

    always_comb begin
        or_o = |pulse_o;
    end

    // R8
    test_fires_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_fire |=> ((pulse_o & en_mask_i & $past(en_mask_i))
                       == (en_mask_i & $past(en_mask_i))));

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulse_o & ~en_mask_i) == '0));

    // R1
    width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_lo >= CNT_W'(MIN_CYC) && cyc_hi <= CNT_W'(MAX_CYC)));

endmodule

// File: tb/pulse_former_bank_bench.sv
module pulse_former_bank_bench;
    localparam int NCH  = 16;
    localparam int CW   = 8;
    localparam int MINC = 2;
    localparam int MAXC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NCH-1:0] hit  = '0;
    logic [NCH-1:0] mode = '0;
    logic [NCH-1:0] mask = '1;
    logic           veto = 1'b0;
    logic           test = 1'b0;
    logic           strobe = 1'b0;
    logic [CW-1:0]  wlo = 8'd128;
    logic [CW-1:0]  whi = 8'd255;
    logic [NCH-1:0] pulse;
    logic           orr;

    int checks = 0;
    int failures = 0;
    int cnt [NCH];
    int or_cnt;
    logic [NCH-1:0] first_pat;

    pulse_former_bank #(.NUM_CH(NCH), .CODE_W(CW), .MIN_CYC(MINC), .MAX_CYC(MAXC))
    u_pulse_former_bank (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .mode_upd_i(mode),
        .en_mask_i(mask), .veto_i(veto), .test_i(test),
        .test_strobe_i(strobe), .width_lo_i(wlo), .width_hi_i(whi),
        .pulse_o(pulse), .or_o(orr)
    );

    // Stimulus table: channel, mode, gap to second hit (0 = single hit)
    localparam int T_N = 12;
    localparam int T_CH  [T_N] = '{0, 3, 5, 6, 1, 2, 4, 9, 12, 15, 10, 8};
    localparam int T_UPD [T_N] = '{0, 0, 0, 0, 1, 1, 1, 0, 0,  0,  1,  1};
    localparam int T_GAP [T_N] = '{0, 4, 7, 8, 3, 6, 7, 0, 21, 22, 10, 20};

    function automatic int exp_width(int code);
        return MINC + ((MAXC - MINC) * code * code) / (255 * 255);
    endfunction

    function automatic int exp_total(int upd, int w, int gap);
        if (gap == 0) return w;
        if (upd != 0) return (gap <= w) ? gap + w : 2 * w;
        return (gap >= w + 2) ? 2 * w : w;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // kind: 0 hit, 1 strobe, 2 external test level, 3 no stimulus
    task automatic run_case(int ch, int kind, int hold, int gap, int n);
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        or_cnt = 0;
        first_pat = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (pulse[c]) cnt[c]++;
            if (orr) or_cnt++;
            if (i == 1) first_pat = pulse;
            if (i == 0) begin
                case (kind)
                    0: hit[ch] = 1'b1;
                    1: strobe = 1'b1;
                    2: test = 1'b1;
                    default: ;
                endcase
            end
            if (i == hold) begin
                hit[ch] = 1'b0;
                strobe = 1'b0;
                test = 1'b0;
            end
            if (gap > 0 && i == gap) hit[ch] = 1'b1;
            if (gap > 0 && i == gap + 1) hit[ch] = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int others;
        int w;
        // R10 reset state
        repeat (3) @(negedge clk);
        check("R10 pulses in reset", int'(pulse), 0);
        check("R10 or in reset", int'(orr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 pulses after reset", int'(pulse), 0);

        // Table walk: R1 R2 R3 R4 R9
        for (int k = 0; k < T_N; k++) begin
            mode = (T_UPD[k] != 0) ? (NCH'(1) << T_CH[k]) : '0;
            run_case(T_CH[k], 0, 1, T_GAP[k], 60);
            w = (T_CH[k] < NCH / 2) ? exp_width(int'(wlo)) : exp_width(int'(whi));
            if (T_GAP[k] == 0)
                check(T_CH[k] >= NCH / 2 ? "R2 upper group width" : "R1 single pulse",
                      cnt[T_CH[k]], w);
            else if (T_UPD[k] != 0)
                check("R4 retrigger length", cnt[T_CH[k]], exp_total(1, w, T_GAP[k]));
            else
                check("R3 ignore or holdoff length", cnt[T_CH[k]], exp_total(0, w, T_GAP[k]));
            check("R9 or cycles", or_cnt, exp_total(T_UPD[k], w, T_GAP[k]));
            others = 0;
            for (int c = 0; c < NCH; c++) if (c != T_CH[k]) others += cnt[c];
            check("R1 other channels quiet", others, 0);
        end
        mode = '0;

        // R1 curve endpoints and a midpoint
        wlo = 8'd0;
        run_case(3, 0, 1, 0, 30);
        check("R1 code 0 width", cnt[3], MINC);
        wlo = 8'd200;
        run_case(3, 0, 1, 0, 30);
        check("R1 code 200 width", cnt[3], exp_width(200));
        wlo = 8'd128;

        // R5 held-high hit
        mode = NCH'(1) << 7;
        run_case(7, 0, 40, 0, 60);
        check("R5 held hit single pulse", cnt[7], exp_width(128));
        mode = '0;

        // R6 disabled channel
        mask = ~(NCH'(1) << 2);
        run_case(2, 0, 1, 0, 20);
        check("R6 masked channel silent", cnt[2], 0);
        check("R6 masked or silent", or_cnt, 0);
        mask = '1;

        // R6 clear mask mid-pulse
        @(negedge clk); hit[1] = 1'b1;
        @(negedge clk); hit[1] = 1'b0;
        @(negedge clk);
        check("R6 pulse running", int'(pulse[1]), 1);
        mask[1] = 1'b0;
        #1;
        check("R6 drop same cycle", int'(pulse[1]), 0);
        check("R6 drop or", int'(orr), 0);
        @(negedge clk); mask[1] = 1'b1;
        run_case(0, 3, 0, 0, 10);
        check("R6 pulse abandoned", cnt[1], 0);

        // R7 veto blocks hits
        veto = 1'b1;
        run_case(0, 0, 1, 0, 20);
        check("R7 vetoed hit", cnt[0], 0);
        check("R7 vetoed or", or_cnt, 0);

        // R8 strobe under veto with partial mask
        mask = 16'hF0F0;
        run_case(0, 1, 1, 0, 40);
        check("R8 strobe pattern", int'(first_pat), 16'hF0F0);
        check("R8 strobe low group", cnt[4], exp_width(128));
        check("R8 strobe high group", cnt[12], exp_width(255));
        check("R8 disabled not fired", cnt[0], 0);
        check("R9 or during test", or_cnt, exp_width(255));

        // R8 external test level edge under veto
        run_case(0, 2, 3, 0, 40);
        check("R8 test level pattern", int'(first_pat), 16'hF0F0);
        check("R8 test level low group", cnt[5], exp_width(128));
        check("R8 test level high group", cnt[13], exp_width(255));
        veto = 1'b0;
        mask = '1;

        // R10 reset mid-pulse
        @(negedge clk); hit[0] = 1'b1;
        @(negedge clk); hit[0] = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R10 reset clears pulse", int'(pulse), 0);
        @(negedge clk); rst_n = 1'b1;
        run_case(0, 3, 0, 0, 10);
        check("R10 no resumed pulse", cnt[0], 0);

        finish_run();
    end

endmodule